// File: doc/BRIEF.md
# Hot-Swap Bus Connect Sequencer

This block is the digital controller of a hot-swappable two-wire bus buffer. It watches two supply rails through digitised threshold flags and samples the four bus levels (SDA and SCL on the backplane side and on the card side). From these it decides the moment at which the card-side pair may safely be joined to a live backplane. While the block waits, it enables a precharge circuit. Once the join is made, it enables the rise-time accelerators. The analog drivers themselves sit outside this block and see only the three control outputs.

The sequence has four steps: undervoltage lockout, a timed initialisation with precharge on, an armed phase that watches for a quiet bus, and the linked state. The link closes on whichever of two events comes first. One is a timed period in which all four lines stay high. The other is a STOP on the backplane pair while all lines are high. Once linked, the block stays linked until a supply fault sends it back to lockout.

Every input is asynchronous to `clk` and passes through a two-flop synchroniser. Durations are given in clock cycles. All pins are plain level signals; the block has no streaming interface.

Top module: `hotswap_connect_seq`

## Requirements
- R1: While either rail is not qualified, `link_o`, `precharge_en_o` and `accel_en_o` are all 0. Rails may become qualified in either order.
- R2: A rail becomes qualified when its `rail_above_hi_i` bit is 1. It loses qualification only when its `rail_below_lo_i` bit is 1. With both bits at 0, the rail keeps its previous state.
- R3: After both rails qualify, the block spends exactly `ENABLE_CYCLES` cycles in initialisation with `precharge_en_o`=1 and `link_o`=0. `precharge_en_o` rises 4 clock edges after the input change that qualifies the second rail.
- R4: Once armed, if all four lines stay high for `IDLE_CYCLES` consecutive cycles, `link_o` rises. If the lines are already high, this happens `ENABLE_CYCLES`+`IDLE_CYCLES`+5 edges after the second rail qualifies.
- R5: A low on any of the four lines during the idle count restarts the count from zero.
- R6: While armed, a backplane STOP with all four lines high sets `link_o` 3 edges after the SDA rise at the input. A STOP is synchronised backplane SDA going from 0 to 1 while backplane SCL is 1 in both the previous and the current sample.
- R7: While linked, `accel_en_o` follows the synchronised `accel_pin_i`. `precharge_en_o` is the inverse of that pin, so precharge stays on when acceleration is off.
- R8: Bus activity of any kind never drops `link_o` while both rails stay qualified.
- R9: A rail losing qualification forces lockout from any state, with all outputs 0. The fault takes priority over a link decision that falls on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_above_hi_i | input | NUM_RAILS | Per rail: supply above the upper (qualify) threshold |
| rail_below_lo_i | input | NUM_RAILS | Per rail: supply below the lower (fault) threshold |
| bp_sda_i | input | 1 | Sampled backplane data level |
| bp_scl_i | input | 1 | Sampled backplane clock level |
| card_sda_i | input | 1 | Sampled card data level |
| card_scl_i | input | 1 | Sampled card clock level |
| accel_pin_i | input | 1 | Accelerator enable pin, 1 = accelerators allowed |
| link_o | output | 1 | Join backplane pair to card pair |
| precharge_en_o | output | 1 | Enable for the line precharge circuit |
| accel_en_o | output | 1 | Enable for the rise-time accelerators |

## Verification
The delicate coincidence is a supply fault that reaches the state machine on the same edge as the idle count completes. The bench times the falling rail flag so that its synchronised, qualified form arrives exactly at the edge where `link_o` would otherwise rise. It first confirms that precharge is still on one edge earlier, which proves the race was really aligned. It then requires `link_o` to stay 0 and every output to drop at that edge. A second coincidence, a STOP arriving while the idle count is running, is judged by the STOP-timed rise of `link_o` three edges after the SDA edge.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef enum logic [1:0] {
    ST_LOCKOUT = 2'd0,
    ST_INIT    = 2'd1,
    ST_ARMED   = 2'd2,
    ST_LINKED  = 2'd3
  } hsc_state_e;
endpackage

// File: rtl/hsc_sync.sv
module hsc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hsc_rail_qual.sv
module hsc_rail_qual #(
  parameter int NUM_RAILS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RAILS-1:0] above_hi_i,
  input  logic [NUM_RAILS-1:0] below_lo_i,
  output logic                 all_ok_o
);
  logic [NUM_RAILS-1:0] ok_q;

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             ok_q[r] <= 1'b0;
      else if (below_lo_i[r]) ok_q[r] <= 1'b0;
      else if (above_hi_i[r]) ok_q[r] <= 1'b1;
    end

    AST_RAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ok_q[r] && !below_lo_i[r] |=> ok_q[r]); // R2
    AST_RAIL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      below_lo_i[r] |=> !ok_q[r]); // R9
  end

  assign all_ok_o = &ok_q;
endmodule

// File: rtl/hsc_bus_watch.sv
module hsc_bus_watch #(
  parameter int IDLE_CYCLES = 14000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic bp_sda_i,
  input  logic bp_scl_i,
  input  logic card_sda_i,
  input  logic card_scl_i,
  output logic idle_done_o,
  output logic stop_seen_o
);
  localparam int IDLE_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_CYCLES);

  logic              all_high;
  logic [IDLE_W-1:0] idle_cnt_q;
  logic              sda_prev_q;
  logic              scl_prev_q;

  assign all_high = bp_sda_i & bp_scl_i & card_sda_i & card_scl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     idle_cnt_q <= '0;
    else if (!arm_i || !all_high)   idle_cnt_q <= '0;
    else if (idle_cnt_q != IDLE_LAST) idle_cnt_q <= idle_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_prev_q <= 1'b0;
      scl_prev_q <= 1'b0;
    end else begin
      sda_prev_q <= bp_sda_i;
      scl_prev_q <= bp_scl_i;
    end
  end

  assign idle_done_o = arm_i && all_high && (idle_cnt_q == IDLE_LAST);
  assign stop_seen_o = arm_i && all_high && !sda_prev_q && scl_prev_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt_q <= IDLE_LAST); // R4
  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !all_high |=> idle_cnt_q == '0); // R5
endmodule

// File: rtl/hotswap_connect_seq.sv
module hotswap_connect_seq
  import hsc_pkg::*;
#(
  parameter int NUM_RAILS     = 2,
  parameter int SYNC_STAGES   = 2,
  parameter int ENABLE_CYCLES = 18000,
  parameter int IDLE_CYCLES   = 14000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RAILS-1:0] rail_above_hi_i,
  input  logic [NUM_RAILS-1:0] rail_below_lo_i,
  input  logic                 bp_sda_i,
  input  logic                 bp_scl_i,
  input  logic                 card_sda_i,
  input  logic                 card_scl_i,
  input  logic                 accel_pin_i,
  output logic                 link_o,
  output logic                 precharge_en_o,
  output logic                 accel_en_o
);
  localparam int EN_W     = $clog2(ENABLE_CYCLES + 1);
  localparam int BUS_BITS = 5;
  localparam logic [EN_W-1:0] EN_LAST = EN_W'(ENABLE_CYCLES - 1);

  logic [NUM_RAILS-1:0] above_s, below_s;
  logic [BUS_BITS-1:0]  bus_s;
  logic                 rails_ok;
  logic                 idle_done, stop_seen;
  logic                 acc_s;
  hsc_state_e           state_q, state_d;
  logic [EN_W-1:0]      init_cnt_q;

  hsc_sync #(.WIDTH(2*NUM_RAILS), .STAGES(SYNC_STAGES)) i_rail_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({rail_above_hi_i, rail_below_lo_i}),
    .q_o({above_s, below_s})
  );

  hsc_sync #(.WIDTH(BUS_BITS), .STAGES(SYNC_STAGES)) i_bus_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({accel_pin_i, bp_sda_i, bp_scl_i, card_sda_i, card_scl_i}),
    .q_o(bus_s)
  );

  assign acc_s = bus_s[4];

  hsc_rail_qual #(.NUM_RAILS(NUM_RAILS)) i_rail_qual (
    .clk(clk), .rst_n(rst_n),
    .above_hi_i(above_s), .below_lo_i(below_s),
    .all_ok_o(rails_ok)
  );

  hsc_bus_watch #(.IDLE_CYCLES(IDLE_CYCLES)) i_bus_watch (
    .clk(clk), .rst_n(rst_n),
    .arm_i(state_q == ST_ARMED),
    .bp_sda_i(bus_s[3]), .bp_scl_i(bus_s[2]),
    .card_sda_i(bus_s[1]), .card_scl_i(bus_s[0]),
    .idle_done_o(idle_done), .stop_seen_o(stop_seen)
  );

  always_comb begin
    state_d = state_q;
    if (!rails_ok) begin
      state_d = ST_LOCKOUT;
    end else begin
      unique case (state_q)
        ST_LOCKOUT: state_d = ST_INIT;
        ST_INIT:    if (init_cnt_q == EN_LAST) state_d = ST_ARMED;
        ST_ARMED:   if (idle_done || stop_seen) state_d = ST_LINKED;
        ST_LINKED:  state_d = ST_LINKED;
        default:    state_d = ST_LOCKOUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOCKOUT;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 init_cnt_q <= '0;
    else if (state_q != ST_INIT) init_cnt_q <= '0;
    else if (init_cnt_q != EN_LAST) init_cnt_q <= init_cnt_q + 1'b1;
  end

  assign link_o         = (state_q == ST_LINKED);
  assign accel_en_o     = link_o && acc_s;
  assign precharge_en_o = (state_q == ST_INIT) || (state_q == ST_ARMED) ||
                          (link_o && !acc_s);

  AST_LOCKOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rails_ok |=> !link_o && !precharge_en_o && !accel_en_o); // R9
  AST_LINK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    link_o && rails_ok |=> link_o); // R8
  AST_LINK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_o) |-> $past(idle_done || stop_seen)); // R4
  AST_ACCEL_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    accel_en_o |-> link_o && !precharge_en_o); // R7
  AST_INIT_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(precharge_en_o) && !link_o |-> $past(!link_o)); // R3
endmodule

// File: tb/test_hotswap_connect_seq.sv
module test_hotswap_connect_seq;
  localparam int E = 8;
  localparam int I = 12;
  localparam int N = E + I + 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] above_hi = 2'b00;
  logic [1:0] below_lo = 2'b11;
  logic bp_sda = 1'b1, bp_scl = 1'b1, card_sda = 1'b1, card_scl = 1'b1;
  logic accel = 1'b1;
  logic link, pre, acc_en;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  always #5 clk = ~clk;

  hotswap_connect_seq #(.NUM_RAILS(2), .SYNC_STAGES(2),
                        .ENABLE_CYCLES(E), .IDLE_CYCLES(I)) i_hotswap_connect_seq (
    .clk(clk), .rst_n(rst_n),
    .rail_above_hi_i(above_hi), .rail_below_lo_i(below_lo),
    .bp_sda_i(bp_sda), .bp_scl_i(bp_scl),
    .card_sda_i(card_sda), .card_scl_i(card_scl),
    .accel_pin_i(accel),
    .link_o(link), .precharge_en_o(pre), .accel_en_o(acc_en)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic edges(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic power_down();
    @(negedge clk);
    above_hi = 2'b00; below_lo = 2'b11;
    edges(8);
    below_lo = 2'b00;
    edges(2);
  endtask

  task automatic power_up_both();
    @(negedge clk);
    above_hi = 2'b11; below_lo = 2'b00;
  endtask

  task automatic t_reset();
    edges(3);
    chk("R1", "reset link", link, 1'b0);
    chk("R1", "reset precharge", pre, 1'b0);
    chk("R1", "reset accel", acc_en, 1'b0);
  endtask

  task automatic t_idle_timing();
    @(negedge clk); above_hi = 2'b01; below_lo = 2'b00;
    edges(20);
    chk("R1", "one rail link", link, 1'b0);
    chk("R1", "one rail precharge", pre, 1'b0);
    @(negedge clk); above_hi = 2'b11;
    edges(3);
    chk("R3", "precharge before init", pre, 1'b0);
    edges(1);
    chk("R3", "precharge in init", pre, 1'b1);
    edges(N - 1 - 4);
    chk("R4", "link one edge early", link, 1'b0);
    chk("R3", "precharge while armed", pre, 1'b1);
    edges(1);
    chk("R4", "link at idle timeout", link, 1'b1);
    chk("R7", "accel with pin high", acc_en, 1'b1);
    chk("R7", "precharge off with pin high", pre, 1'b0);
    power_down();
  endtask

  task automatic t_rail_order();
    @(negedge clk); above_hi = 2'b10;
    edges(15);
    chk("R1", "card rail first link", link, 1'b0);
    @(negedge clk); above_hi = 2'b11;
    edges(N);
    chk("R1", "reverse order link", link, 1'b1);
    power_down();
  endtask

  task automatic t_stop();
    @(negedge clk); bp_sda = 1'b0;
    power_up_both();
    edges(E + 10);
    chk("R6", "no link with sda low", link, 1'b0);
    @(negedge clk); bp_sda = 1'b1;
    edges(2);
    chk("R6", "link before stop seen", link, 1'b0);
    edges(1);
    chk("R6", "link after stop", link, 1'b1);
    power_down();
  endtask

  task automatic t_restart();
    power_up_both();
    edges(17);
    @(negedge clk); card_scl = 1'b0;
    @(negedge clk); card_scl = 1'b1;
    edges(14);
    chk("R5", "link before restarted count ends", link, 1'b0);
    edges(1);
    chk("R5", "link after restarted count", link, 1'b1);
    power_down();
  endtask

  task automatic t_acc_low_and_sticky();
    @(negedge clk); accel = 1'b0;
    power_up_both();
    edges(N + 2);
    chk("R7", "link with pin low", link, 1'b1);
    chk("R7", "precharge kept with pin low", pre, 1'b1);
    chk("R7", "accel off with pin low", acc_en, 1'b0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      bp_sda = k[0]; bp_scl = k[1]; card_sda = ~k[0]; card_scl = k[2];
      edges(3);
      chk("R8", "link during bus traffic", link, 1'b1);
    end
    @(negedge clk); bp_sda = 1; bp_scl = 1; card_sda = 1; card_scl = 1; accel = 1'b1;
    edges(3);
    chk("R7", "accel follows pin", acc_en, 1'b1);
    chk("R7", "precharge drops with pin", pre, 1'b0);
    power_down();
  endtask

  task automatic t_hysteresis();
    power_up_both();
    edges(N + 2);
    @(negedge clk); above_hi = 2'b10; below_lo = 2'b00;
    edges(10);
    chk("R2", "link held between thresholds", link, 1'b1);
    @(negedge clk); below_lo = 2'b01;
    edges(4);
    chk("R9", "link dropped on fault", link, 1'b0);
    chk("R9", "precharge dropped on fault", pre, 1'b0);
    chk("R9", "accel dropped on fault", acc_en, 1'b0);
    power_down();
  endtask

  task automatic t_fault_race();
    power_up_both();
    edges(E + I + 1);
    @(negedge clk); above_hi = 2'b10; below_lo = 2'b01;
    edges(3);
    chk("R9", "armed just before race edge", pre, 1'b1);
    edges(1);
    chk("R9", "no link on race edge", link, 1'b0);
    chk("R9", "precharge off on race edge", pre, 1'b0);
    edges(5);
    chk("R9", "still locked after race", link, 1'b0);
    power_down();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    below_lo = 2'b00;
    t_reset();
    t_idle_timing();
    t_rail_order();
    t_stop();
    t_restart();
    t_acc_low_and_sticky();
    t_hysteresis();
    t_fault_race();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule